// File: doc/BRIEF.md
# PHY Resume Packet Decoder

The decoder takes 64-bit physical-layer control packets from a serial bus PHY. They arrive as two 32-bit quadlets, each marked by a valid strobe. It checks that the packet is intact: the second quadlet must be the exact bitwise complement of the first. It also checks the fixed fields of the header. When the header holds the extended type for a resume command, the decoder issues a one-cycle resume request on each port that is both connected and suspended at the moment the packet completes.

Resume packets are broadcast, so the destination node identifier is not compared. The block sends nothing back. A packet that fails a check is dropped, and the block reports it with a single-cycle error pulse. A packet with a valid header and any other extended type is dropped without an error.

Control is a two-state machine. `ST_HEAD` waits for the header quadlet and stores it. Transition `HEAD_TO_CHECK` fires on a valid quadlet. `ST_CHECK` waits for the complement quadlet. Transition `CHECK_TO_HEAD` fires on the next valid quadlet, which completes the pair. Idle cycles hold the current state.

Top module: `phy_resume_rx`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `resume_pulse` is all zero, `pkt_err` is 0, and the next valid quadlet is taken as a header.
- R2: Quadlets are taken only in cycles where `q_valid` is 1. Any number of idle cycles before or between the two quadlets leaves the pairing and the result unchanged.
- R3: If the second quadlet is not the bitwise complement of the first, `pkt_err` pulses for one cycle and `resume_pulse` stays all zero.
- R4: Bit 31 is taken as bit 0 of the header. The header must hold 2'b01 in bits [31:30], 2'b00 in bits [23:22] and zero in bits [17:0]. If the complement check passes but any of these fields is wrong, `pkt_err` pulses and no resume is issued.
- R5: When a packet passes both checks and the extended type field, bits [21:18], equals 4'hF, `resume_pulse[i]` is 1 exactly for the ports where `port_conn[i]` and `port_susp[i]` are both 1.
- R6: When a packet passes both checks and has an extended type other than 4'hF, both outputs stay zero.
- R7: The outputs for a packet appear in the cycle after the clock edge that takes the second quadlet, and they last exactly one cycle.
- R8: `port_conn` and `port_susp` are sampled only at the edge that takes the second quadlet. Changes to them at any other time do not affect the result.
- R9: The node identifier field, bits [29:24], can hold any value and does not affect the decode.
- R10: The header quadlet of the next packet may arrive in the same cycle that the previous packet's outputs are shown. Both packets are then decoded correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_valid | input | 1 | Quadlet strobe |
| q_data | input | 32 | Quadlet; bit 31 is header bit 0 |
| port_conn | input | NPORTS | Per-port connected status |
| port_susp | input | NPORTS | Per-port suspended status |
| resume_pulse | output | NPORTS | Per-port one-cycle resume request |
| pkt_err | output | 1 | One-cycle malformed-packet flag |

## Verification
Two functions can fall in the same cycle. The first is the registered result of one packet. The second is the acceptance of the next packet's header quadlet. The bench provokes this by sending packets with no gap, so the next header is driven in the very cycle where the previous resume pulses are checked. It then confirms that the old pulses are correct and that the new packet still decodes to its own expected mask. A second overlap is tested by changing the port status in the cycle right after the closing quadlet is taken. The result is judged correct only if it follows the status sampled at that edge.

// File: rtl/phy_resume_pkg.sv
package phy_resume_pkg;

    localparam int QW = 32;

    // header field positions (bit 31 is header bit 0)
    localparam int TAG_HI   = 31;
    localparam int TAG_LO   = 30;
    localparam int NODE_HI  = 29;
    localparam int NODE_LO  = 24;
    localparam int PADA_HI  = 23;
    localparam int PADA_LO  = 22;
    localparam int KIND_HI  = 21;
    localparam int KIND_LO  = 18;
    localparam int PADB_HI  = 17;

    localparam logic [1:0] TAG_VALUE   = 2'b01;
    localparam logic [3:0] KIND_RESUME = 4'hF;

    typedef enum logic [0:0] {
        ST_HEAD  = 1'b0,
        ST_CHECK = 1'b1
    } rx_state_e;

    typedef struct packed {
        logic pair_ok;
        logic hdr_ok;
        logic is_resume;
    } verdict_t;

endpackage

// File: rtl/phy_resume_seq.sv
module phy_resume_seq
    import phy_resume_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          q_valid,
    input  logic [QW-1:0] q_data,
    output logic [QW-1:0] head_q,
    output logic          pair_fire
);

    rx_state_e state_q;
    rx_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HEAD;
            head_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_HEAD && q_valid) begin
                head_q <= q_data;
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        pair_fire = 1'b0;
        unique case (state_q)
            ST_HEAD: begin
                if (q_valid) begin
                    state_d = ST_CHECK;      // HEAD_TO_CHECK
                end
            end
            ST_CHECK: begin
                if (q_valid) begin
                    pair_fire = 1'b1;
                    state_d   = ST_HEAD;     // CHECK_TO_HEAD
                end
            end
            default: state_d = ST_HEAD;
        endcase
    end

    AST_RETURN_TO_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        pair_fire |=> (state_q == ST_HEAD)); // R10

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !q_valid |=> $stable(state_q)); // R2

    AST_HEAD_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK && !q_valid) |=> $stable(head_q)); // R2

endmodule

// File: rtl/phy_resume_check.sv
module phy_resume_check
    import phy_resume_pkg::*;
(
    input  logic [QW-1:0] head,
    input  logic [QW-1:0] tail,
    output verdict_t      verdict
);

    logic tag_ok;
    logic pad_ok;

    always_comb begin
        tag_ok = (head[TAG_HI:TAG_LO] == TAG_VALUE);
        pad_ok = (head[PADA_HI:PADA_LO] == 2'b00) && (head[PADB_HI:0] == '0);
        verdict.pair_ok   = (tail == ~head);
        verdict.hdr_ok    = tag_ok && pad_ok;
        verdict.is_resume = (head[KIND_HI:KIND_LO] == KIND_RESUME);
    end

endmodule

// File: rtl/phy_resume_ports.sv
module phy_resume_ports
    import phy_resume_pkg::*;
#(
    parameter int NPORTS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  verdict_t          verdict,
    input  logic [NPORTS-1:0] port_conn,
    input  logic [NPORTS-1:0] port_susp,
    output logic [NPORTS-1:0] resume_q,
    output logic              err_q
);

    logic              good;
    logic              act;
    logic [NPORTS-1:0] want;

    always_comb begin
        good = verdict.pair_ok && verdict.hdr_ok;
        act  = fire && good && verdict.is_resume;
    end

    for (genvar gi = 0; gi < NPORTS; gi++) begin : g_port
        always_comb begin
            want[gi] = act && port_conn[gi] && port_susp[gi];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resume_q <= '0;
            err_q    <= 1'b0;
        end else begin
            resume_q <= want;
            err_q    <= fire && !good;
        end
    end

    AST_ERR_NO_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> (resume_q == '0)); // R3

    AST_RESUME_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|resume_q) |=> (resume_q == '0)); // R7

    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> !err_q); // R3

    AST_MASKED_PORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (|resume_q) |-> ((resume_q & ~($past(port_conn) & $past(port_susp))) == '0)); // R5

endmodule

// File: rtl/phy_resume_rx.sv
module phy_resume_rx
    import phy_resume_pkg::*;
#(
    parameter int NPORTS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q_valid,
    input  logic [31:0]       q_data,
    input  logic [NPORTS-1:0] port_conn,
    input  logic [NPORTS-1:0] port_susp,
    output logic [NPORTS-1:0] resume_pulse,
    output logic              pkt_err
);

    logic [QW-1:0] head_q;
    logic          pair_fire;
    verdict_t      verdict;

    phy_resume_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .q_valid   (q_valid),
        .q_data    (q_data),
        .head_q    (head_q),
        .pair_fire (pair_fire)
    );

    phy_resume_check u_check (
        .head    (head_q),
        .tail    (q_data),
        .verdict (verdict)
    );

    phy_resume_ports #(.NPORTS(NPORTS)) u_ports (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (pair_fire),
        .verdict   (verdict),
        .port_conn (port_conn),
        .port_susp (port_susp),
        .resume_q  (resume_pulse),
        .err_q     (pkt_err)
    );

    AST_OUT_AFTER_QUADLET: assert property (@(posedge clk) disable iff (!rst_n)
        ((|resume_pulse) || pkt_err) |-> $past(q_valid)); // R7

    AST_ERR_NEEDS_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_err |-> !$past(verdict.pair_ok && verdict.hdr_ok)); // R4

endmodule

// File: tb/phy_resume_rx_test.sv
`timescale 1ns/1ps
module phy_resume_rx_test;

    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          q_valid = 1'b0;
    logic [31:0]   q_data = '0;
    logic [NP-1:0] port_conn = '0;
    logic [NP-1:0] port_susp = '0;
    logic [NP-1:0] resume_pulse;
    logic          pkt_err;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    phy_resume_rx #(.NPORTS(NP)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .q_valid      (q_valid),
        .q_data       (q_data),
        .port_conn    (port_conn),
        .port_susp    (port_susp),
        .resume_pulse (resume_pulse),
        .pkt_err      (pkt_err)
    );

    function automatic logic [31:0] mk(logic [5:0] node, logic [3:0] kind);
        return {2'b01, node, 2'b00, kind, 18'b0};
    endfunction

    task automatic chk(string req, logic [NP-1:0] exp_res, logic exp_err);
        n_checks++;
        if (resume_pulse !== exp_res || pkt_err !== exp_err) begin
            n_fail++;
            $display("FAIL %s: resume=%b err=%b expected resume=%b err=%b",
                     req, resume_pulse, pkt_err, exp_res, exp_err);
        end
    endtask

    task automatic drive(logic v, logic [31:0] d);
        @(negedge clk);
        q_valid = v;
        q_data  = d;
    endtask

    // sends a pair, then idles; returns at the negedge where results show
    task automatic send(logic [31:0] a, logic [31:0] b);
        drive(1'b1, a);
        drive(1'b1, b);
        drive(1'b0, 32'h0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 in reset", '0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", '0, 1'b0);
    endtask

    task automatic t_resume_basic;
        port_conn = 4'b1011;
        port_susp = 4'b1110;
        send(mk(6'd5, 4'hF), ~mk(6'd5, 4'hF));
        chk("R5 masked resume", 4'b1010, 1'b0);
        @(negedge clk);
        chk("R7 pulse ends", '0, 1'b0);
        port_conn = 4'b1111;
        port_susp = 4'b1111;
        send(mk(6'd0, 4'hF), ~mk(6'd0, 4'hF));
        chk("R5 all ports", 4'b1111, 1'b0);
        port_conn = 4'b0101;
        port_susp = 4'b1010;
        send(mk(6'd0, 4'hF), ~mk(6'd0, 4'hF));
        chk("R5 no overlap", 4'b0000, 1'b0);
    endtask

    task automatic t_bad_inverse;
        port_conn = 4'b1111;
        port_susp = 4'b1111;
        send(mk(6'd3, 4'hF), ~mk(6'd3, 4'hF) ^ 32'h0000_0100);
        chk("R3 inverse mismatch", '0, 1'b1);
        @(negedge clk);
        chk("R3 error one cycle", '0, 1'b0);
        send(mk(6'd3, 4'hF), mk(6'd3, 4'hF));
        chk("R3 equal quadlets", '0, 1'b1);
    endtask

    task automatic t_bad_format;
        logic [31:0] h;
        port_conn = 4'b1111;
        port_susp = 4'b1111;
        h = mk(6'd1, 4'hF) | 32'hC000_0000;
        send(h, ~h);
        chk("R4 tag 11", '0, 1'b1);
        h = mk(6'd1, 4'hF) | 32'h0040_0000;
        send(h, ~h);
        chk("R4 pad bits 8-9", '0, 1'b1);
        h = mk(6'd1, 4'hF) | 32'h0000_0001;
        send(h, ~h);
        chk("R4 trailing zero bits", '0, 1'b1);
    endtask

    task automatic t_other_type;
        port_conn = 4'b1111;
        port_susp = 4'b1111;
        send(mk(6'd2, 4'h1), ~mk(6'd2, 4'h1));
        chk("R6 type 1 ignored", '0, 1'b0);
        send(mk(6'd2, 4'hE), ~mk(6'd2, 4'hE));
        chk("R6 type E ignored", '0, 1'b0);
    endtask

    task automatic t_gaps;
        port_conn = 4'b0110;
        port_susp = 4'b0111;
        drive(1'b0, 32'hFFFF_FFFF);
        drive(1'b1, mk(6'd9, 4'hF));
        drive(1'b0, 32'h1234_5678);
        drive(1'b0, 32'h0);
        drive(1'b1, ~mk(6'd9, 4'hF));
        drive(1'b0, 32'h0);
        chk("R2 idle between quadlets", 4'b0110, 1'b0);
    endtask

    task automatic t_mask_timing;
        port_conn = 4'b0000;
        port_susp = 4'b0000;
        drive(1'b1, mk(6'd4, 4'hF));
        port_conn = 4'b1100;
        port_susp = 4'b0101;
        drive(1'b1, ~mk(6'd4, 4'hF));
        drive(1'b0, 32'h0);
        port_conn = 4'b1111;
        port_susp = 4'b1111;
        chk("R8 masks at second quadlet", 4'b0100, 1'b0);
    endtask

    task automatic t_node_ids;
        port_conn = 4'b0001;
        port_susp = 4'b0001;
        send(mk(6'd63, 4'hF), ~mk(6'd63, 4'hF));
        chk("R9 node 63", 4'b0001, 1'b0);
        send(mk(6'd42, 4'hF), ~mk(6'd42, 4'hF));
        chk("R9 node 42", 4'b0001, 1'b0);
    endtask

    task automatic t_back_to_back;
        port_conn = 4'b0011;
        port_susp = 4'b0011;
        drive(1'b1, mk(6'd7, 4'hF));
        drive(1'b1, ~mk(6'd7, 4'hF));
        drive(1'b1, mk(6'd8, 4'hF));
        port_conn = 4'b1000;
        port_susp = 4'b1000;
        chk("R10 first packet with new header", 4'b0011, 1'b0);
        drive(1'b1, ~mk(6'd8, 4'hF));
        chk("R10 gap cycle", '0, 1'b0);
        drive(1'b0, 32'h0);
        chk("R10 second packet", 4'b1000, 1'b0);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_resume_basic();
        t_bad_inverse();
        t_bad_format();
        t_other_type();
        t_gaps();
        t_mask_timing();
        t_node_ids();
        t_back_to_back();
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule